// File: doc/BRIEF.md
# Fractional-N Modulus Accumulator Controller

This block sets the division ratio of a dual-modulus divider so that, averaged over many divider output cycles, the ratio is P + K/F. A phase accumulator of ACC_W bits sets the denominator F = 2^ACC_W. Once per divider output cycle it adds the numerator K to its stored phase. When that addition overflows, the divider counts P+1 input clocks for the next output cycle; otherwise it counts P. The carry rate is K/F of the divider output rate, which gives the fractional part.

A behavioural dual-modulus down-counter is included. It runs on the input clock `clk_i`, loads the selected ratio and marks the last clock of each output cycle on `div_pulse_o`. That pulse also steps the accumulator. `k_i` and `p_i` are sampled only at the clock edge that closes an output cycle. Changing them in the middle of a cycle therefore never disturbs the modulus select or the cycle length in progress. After reset, the block runs one start-up cycle of a single clock before the first programmed cycle.

Top module: `fracn_mod_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `mod_sel_o` is 0, `div_pulse_o` is 1 and `div_val_o` reads 1, which is the length of the one-clock start-up cycle.
- R2: Each divider output cycle lasts exactly `div_val_o` clocks of `clk_i`, and `div_pulse_o` is high only on the last of them.
- R3: At each clock edge where `div_pulse_o` is high, the phase becomes (phase + `k_i`) mod F. For the output cycle that follows, `mod_sel_o` equals the carry of that addition (1 = extended modulus).
- R4: During an output cycle, `div_val_o` equals `p_i` as sampled at the edge that opened the cycle, plus `mod_sel_o`.
- R5: Counting from reset with a constant K, any F consecutive output cycles contain exactly K cycles with `mod_sel_o` = 1 and span F·P + K clocks.
- R6: With `k_i` = 0, `mod_sel_o` stays 0 and every cycle lasts P clocks.
- R7: After reset with a constant nonzero K, the first output cycle with `mod_sel_o` = 1 is cycle number ceil(F/K), counting the first programmed cycle as 1.
- R8: With a constant K, the sequence of `mod_sel_o` values repeats with a period of F output cycles.
- R9: Values placed on `k_i` and `p_i` at any clock edge other than the one that closes a cycle have no effect. A new K applies to the cycle opened by the next closing edge, and `mod_sel_o` and `div_val_o` hold steady inside a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| k_i | input | ACC_W | Fractional numerator K (0..F-1) |
| p_i | input | P_W | Integer base modulus P (at least 2) |
| mod_sel_o | output | 1 | 1 selects P+1 for the current output cycle |
| div_val_o | output | P_W+1 | Division value in force for the current output cycle |
| div_pulse_o | output | 1 | High on the last input clock of each output cycle |

## Verification
The bench runs several numerators against a scoreboard of expected modulus and length for each cycle. The hardest cases are K = 0, K = F-1, K = 1 (first carry only at cycle F) and K = F/2. An off-by-one in the carry logic would move the first extended cycle or change the carry count over F cycles. That would shift the average ratio away from P + K/F. K is changed mid-run, and `k_i`/`p_i` are scrambled inside open cycles. A design that samples them continuously instead of at the closing edge would stretch or shorten cycles and mismatch the queued expectations. If the counter loaded the wrong value, cycle lengths would no longer match `div_val_o`.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  typedef enum logic {
    MOD_BASE = 1'b0,
    MOD_PLUS = 1'b1
  } mod_e;
endpackage

// File: rtl/fracn_phase_acc.sv
module fracn_phase_acc #(
  parameter int unsigned ACC_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic [ACC_W-1:0]    k_i,
  output fracn_pkg::mod_e     mod_nxt_o,
  output fracn_pkg::mod_e     mod_o
);
  localparam int unsigned SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] phase_q;
  logic [SUM_W-1:0] sum;
  fracn_pkg::mod_e  mod_q;

  assign sum       = {1'b0, phase_q} + {1'b0, k_i};
  assign mod_nxt_o = fracn_pkg::mod_e'(sum[ACC_W]);
  assign mod_o     = mod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      mod_q   <= fracn_pkg::MOD_BASE;
    end else if (step_i) begin
      phase_q <= sum[ACC_W-1:0];
      mod_q   <= mod_nxt_o;
    end
  end
endmodule

// File: rtl/fracn_ratio_sel.sv
module fracn_ratio_sel #(
  parameter int unsigned P_W = 6
) (
  input  logic [P_W-1:0]   p_i,
  input  fracn_pkg::mod_e  mod_i,
  output logic [P_W:0]     ratio_o
);
  assign ratio_o = {1'b0, p_i} + (P_W+1)'(mod_i == fracn_pkg::MOD_PLUS);
endmodule

// File: rtl/fracn_dm_counter.sv
module fracn_dm_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] load_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == CNT_W'(1));

  // reset value 1 gives a one-clock start-up cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CNT_W'(1);
    else if (tick_o) cnt_q <= load_i;
    else             cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/fracn_mod_ctrl.sv
module fracn_mod_ctrl #(
  parameter int unsigned ACC_W = 4,
  parameter int unsigned P_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] k_i,
  input  logic [P_W-1:0]   p_i,
  output logic             mod_sel_o,
  output logic [P_W:0]     div_val_o,
  output logic             div_pulse_o
);
  localparam int unsigned CNT_W = P_W + 1;

  fracn_pkg::mod_e  mod_nxt, mod_cur;
  logic             tick;
  logic [P_W-1:0]   p_q;
  logic [CNT_W-1:0] load_val;

  fracn_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (tick),
    .k_i       (k_i),
    .mod_nxt_o (mod_nxt),
    .mod_o     (mod_cur)
  );

  // ratio for the cycle about to open, and for the cycle in force
  fracn_ratio_sel #(.P_W(P_W)) u_load_sel (
    .p_i     (p_i),
    .mod_i   (mod_nxt),
    .ratio_o (load_val)
  );

  fracn_ratio_sel #(.P_W(P_W)) u_cur_sel (
    .p_i     (p_q),
    .mod_i   (mod_cur),
    .ratio_o (div_val_o)
  );

  fracn_dm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_val),
    .tick_o (tick)
  );

  // reset to 1 so div_val_o matches the start-up cycle length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   p_q <= P_W'(1);
    else if (tick) p_q <= p_i;
  end

  assign mod_sel_o   = (mod_cur == fracn_pkg::MOD_PLUS);
  assign div_pulse_o = tick;
endmodule

// File: rtl/fracn_mod_ctrl_chk.sv
module fracn_mod_ctrl_chk #(
  parameter int unsigned ACC_W = 4,
  parameter int unsigned P_W   = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ACC_W-1:0] k_i,
  input logic [P_W-1:0]   p_i,
  input logic             mod_sel_o,
  input logic [P_W:0]     div_val_o,
  input logic             div_pulse_o
);
  localparam int unsigned CNT_W = P_W + 1;

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= CNT_W'(1);
    else if (div_pulse_o) run_q <= CNT_W'(1);
    else                  run_q <= run_q + CNT_W'(1);
  end

  assert_pulse_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |-> (run_q == div_val_o));

  assert_no_early_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_pulse_o |-> (run_q < div_val_o));

  assert_div_val_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> (div_val_o == ({1'b0, $past(p_i)} + CNT_W'(mod_sel_o))));

  assert_k_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_o && (k_i == '0)) |=> !mod_sel_o);

  assert_steady_in_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_pulse_o |=> ($stable(mod_sel_o) && $stable(div_val_o)));
endmodule

bind fracn_mod_ctrl fracn_mod_ctrl_chk #(.ACC_W(ACC_W), .P_W(P_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .k_i         (k_i),
  .p_i         (p_i),
  .mod_sel_o   (mod_sel_o),
  .div_val_o   (div_val_o),
  .div_pulse_o (div_pulse_o)
);

// File: tb/fracn_mod_ctrl_tb.sv
module fracn_mod_ctrl_tb;
  localparam int ACC_W = 4;
  localparam int P_W   = 6;
  localparam int F     = 1 << ACC_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [ACC_W-1:0] k_i = '0;
  logic [P_W-1:0]   p_i = P_W'(2);
  logic             mod_sel_o;
  logic [P_W:0]     div_val_o;
  logic             div_pulse_o;

  always #5 clk_i = ~clk_i;

  fracn_mod_ctrl #(.ACC_W(ACC_W), .P_W(P_W)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .k_i         (k_i),
    .p_i         (p_i),
    .mod_sel_o   (mod_sel_o),
    .div_val_o   (div_val_o),
    .div_pulse_o (div_pulse_o)
  );

  typedef struct packed {
    logic         m;
    logic [P_W:0] v;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int   total = 0, bad = 0;
  bit   done = 0;
  int   acc_m = 0;
  bit   seen = 0;
  int   len = 0, obs_periods = 0, obs_carries16 = 0, obs_clks16 = 0, obs_first = 0;
  bit   obs_bits [64];

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: closes each output cycle and pops its expectation
  always @(negedge clk_i) if (rst_ni) begin
    len++;
    if (div_pulse_o) begin
      if (seen) begin
        obs_periods++;
        if (obs_periods <= F) begin
          obs_clks16    += len;
          obs_carries16 += int'(mod_sel_o);
        end
        if (obs_periods <= 64) obs_bits[obs_periods-1] = mod_sel_o;
        if (mod_sel_o && obs_first == 0) obs_first = obs_periods;
        chk(len == int'(div_val_o), "R2 cycle length", len, int'(div_val_o));
        if (q.size() > 0) begin
          mon_e = q.pop_front();
          chk(mod_sel_o == mon_e.m, "R3 modulus select", int'(mod_sel_o), int'(mon_e.m));
          chk(div_val_o == mon_e.v, "R4 divide value", int'(div_val_o), int'(mon_e.v));
        end
      end
      seen = 1;
      len  = 0;
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    k_i = '0;
    p_i = P_W'(2);
    repeat (3) @(negedge clk_i);
    q.delete();
    seen = 0; len = 0; obs_periods = 0; obs_carries16 = 0; obs_clks16 = 0; obs_first = 0;
    acc_m = 0;
    @(posedge clk_i);
    #2 rst_ni = 1'b1;
    #1;
    chk(mod_sel_o == 1'b0, "R1 reset mod_sel", int'(mod_sel_o), 0);
    chk(div_pulse_o == 1'b1, "R1 reset pulse", int'(div_pulse_o), 1);
    chk(div_val_o == 7'd1, "R1 reset div_val", int'(div_val_o), 1);
  endtask

  // driver: programs one output cycle and queues its expectation
  task automatic step(int p, int k, bit glitch);
    int s;
    bit c;
    do @(negedge clk_i); while (!div_pulse_o);
    p_i = P_W'(p);
    k_i = ACC_W'(k);
    s = acc_m + k;
    c = (s >= F);
    acc_m = s % F;
    q.push_back(exp_t'({c, 7'(p + int'(c))}));
    if (glitch) begin
      @(negedge clk_i);
      k_i = ~ACC_W'(k);
      p_i = P_W'(p + 5);
    end
  endtask

  task automatic wait_periods(int n);
    while (obs_periods < n) @(negedge clk_i);
  endtask

  task automatic run_case(int p, int k, bit glitch);
    int bad0;
    int mism;
    bad0 = bad;
    do_reset();
    for (int i = 0; i < 2*F; i++) step(p, k, glitch);
    wait_periods(2*F);
    chk(obs_carries16 == k, "R5 carries over F cycles", obs_carries16, k);
    chk(obs_clks16 == F*p + k, "R5 clocks over F cycles", obs_clks16, F*p + k);
    if (k == 0) chk(obs_first == 0, "R6 no carry with K=0", obs_first, 0);
    else        chk(obs_first == (F + k - 1) / k, "R7 first carry cycle", obs_first, (F + k - 1) / k);
    mism = 0;
    for (int i = 0; i < F; i++) if (obs_bits[i] != obs_bits[i+F]) mism++;
    chk(mism == 0, "R8 carry pattern period F", mism, 0);
    if (glitch) chk(bad == bad0, "R9 mid-cycle input changes ignored", bad - bad0, 0);
  endtask

  initial begin
    run_case(8, 3, 1'b0);
    run_case(5, 0, 1'b0);
    run_case(12, 15, 1'b1);
    run_case(2, 8, 1'b0);
    run_case(3, 1, 1'b1);
    run_case(20, 5, 1'b1);
    // R9: K and P changed between cycles without reset
    do_reset();
    for (int i = 0; i < 5; i++) step(8, 3, 1'b0);
    for (int i = 0; i < 5; i++) step(8, 10, 1'b0);
    for (int i = 0; i < 6; i++) step(9, 7, 1'b1);
    wait_periods(16);
    chk(q.size() == 0, "R9 all queued cycles observed", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule